// File: doc/BRIEF.md
# Slave Serial Audio Port with Short-Frame Option

This block is the serial side of a 16-bit mono codec's audio interface when the codec is a clock slave. A host supplies the bit clock and the frame sync. The port samples the host's serial input into a 16-bit word for the playback path. It also shifts a 16-bit capture word out on the serial output. The bit clock, the frame sync and the serial input are oversampled by the block's system clock. Every serial event therefore appears as a single-cycle pulse in the system clock domain.

Each frame has two channels. The first channel carries nothing and the serial output stays low during it. The second channel carries the 16 data bits, most significant bit first. In full framing the first channel lasts 16 bit-clock periods, so a frame is 32 periods long. In short framing the first channel lasts one period, so a frame is 17 periods long. The data channel never gets shorter. A new rising edge of the frame sync that arrives before a frame finishes abandons that frame and starts counting again.

Top module: `sap_port`

## Requirements
- R1: The serial output changes only in the system-clock cycle that follows a detected bit-clock rising edge. The serial input is taken only at detected bit-clock falling edges. A bit-clock input change shows on the outputs two system clocks later: one input register stage plus one output register.
- R2: A frame starts at a bit-clock rising edge where the frame sync is sampled high and was sampled low at the previous rising edge. At that start, tx_data_i is captured and tx_load_o pulses high for one clock.
- R3: With mode_i = 0 (full framing), the frame start is rising edge 0. The 16 data bits go out on rising edges 16 to 31, bit 15 first, and are taken in on the falling edges of those same periods.
- R4: With mode_i = 1 (short framing), the first channel is period 0 only. The data bits go out and come in on periods 1 to 16, bit 15 first.
- R5: After the falling edge that samples bit 0, rx_data_o holds the received word and rx_valid_o is high for exactly one clock.
- R6: sdo_o is 0 in the first channel, after the last data period of a frame, and while no frame is in progress.
- R7: mode_i is sampled only at a frame start that occurs while no frame is in progress. Changes to mode_i during a frame, or at a restart that aborts a frame, do not change that frame's timing.
- R8: A frame start during an unfinished frame discards the partial frame, so no rx_valid_o pulse is produced for it. The new frame restarts at count 0 and reloads tx_data_i.
- R9: While rst_ni is low, sdo_o, tx_load_o and rx_valid_o are 0 and rx_data_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Bit clock from the host |
| fsync_i | input | 1 | Frame sync from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| mode_i | input | 1 | 0 = 32-period frame, 1 = 17-period frame |
| tx_data_i | input | 16 | Word to send, captured at frame start |
| tx_load_o | output | 1 | One-clock pulse when tx_data_i is captured |
| rx_data_o | output | 16 | Last complete received word |
| rx_valid_o | output | 1 | One-clock pulse when rx_data_o is updated |

## Verification
The port is driven with single full frames, back-to-back full frames, and single and back-to-back short frames. The data words are all ones, a single set bit at either end, and mixed patterns. These tell a correct data-channel offset and bit order apart from shifts that are one period off or reversed. A mode change in mid-frame separates "sampled at idle start" from "sampled continuously". Aborted frames in both modes show whether a partial word leaks out and whether a restart keeps the latched mode. A behavioural model compared on every system clock checks the exact cycle of every output change.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic {
    FRAME_FULL  = 1'b0,
    FRAME_SHORT = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/sap_edge.sv
module sap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic fsync_o,
  output logic sdi_o
);
  logic bclk_q, bclk_qq, fsync_q, sdi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      fsync_q <= 1'b0;
      sdi_q   <= 1'b0;
    end else begin
      bclk_q  <= bclk_i;
      bclk_qq <= bclk_q;
      fsync_q <= fsync_i;
      sdi_q   <= sdi_i;
    end
  end

  assign rise_o  = bclk_q & ~bclk_qq;
  assign fall_o  = ~bclk_q & bclk_qq;
  assign fsync_o = fsync_q;
  assign sdi_o   = sdi_q;
endmodule

// File: rtl/sap_frame_ctrl.sv
module sap_frame_ctrl
  import sap_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic fsync_i,
  input  logic mode_i,
  output logic start_o,
  output logic tx_step_o,
  output logic rx_step_o,
  output logic rx_done_o
);
  localparam int unsigned CW = $clog2(2 * SAMPLE_W) + 1;

  frame_mode_e   mode_q;
  logic [CW-1:0] cnt_q, cnt_nx, base, last;
  logic          in_frame_q, fs_last_q, fs_edge;

  assign fs_edge = rise_i & fsync_i & ~fs_last_q;
  assign base    = (mode_q == FRAME_SHORT) ? CW'(1) : CW'(SAMPLE_W);
  assign last    = base + CW'(SAMPLE_W - 1);
  assign cnt_nx  = cnt_q + CW'(1);

  assign start_o   = fs_edge;
  assign tx_step_o = rise_i & ~fs_edge & in_frame_q & (cnt_nx >= base) & (cnt_nx <= last);
  assign rx_step_o = fall_i & in_frame_q & (cnt_q >= base) & (cnt_q <= last);
  assign rx_done_o = rx_step_o & (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= FRAME_FULL;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      fs_last_q  <= 1'b0;
    end else if (rise_i) begin
      fs_last_q <= fsync_i;
      if (fs_edge) begin
        in_frame_q <= 1'b1;
        cnt_q      <= '0;
        // restart on abort keeps the latched mode
        if (!in_frame_q) mode_q <= frame_mode_e'(mode_i);
      end else if (in_frame_q) begin
        cnt_q <= cnt_nx;
      end
    end else if (rx_done_o) begin
      in_frame_q <= 1'b0;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frame_q |-> cnt_q <= last);
  assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frame_q |=> mode_q == $past(mode_q));
  assert_done_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !in_frame_q || $past(fs_edge));
endmodule

// File: rtl/sap_shifter.sv
module sap_shifter #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic                start_i,
  input  logic                tx_step_i,
  input  logic                rx_step_i,
  input  logic                rx_done_i,
  input  logic                sdi_i,
  input  logic [SAMPLE_W-1:0] tx_data_i,
  output logic                sdo_o,
  output logic                tx_load_o,
  output logic                rx_valid_o,
  output logic [SAMPLE_W-1:0] rx_data_o
);
  logic [SAMPLE_W-1:0] tx_sh_q, rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q   <= '0;
      sdo_o     <= 1'b0;
      tx_load_o <= 1'b0;
    end else begin
      tx_load_o <= start_i;
      if (start_i)        tx_sh_q <= tx_data_i;
      else if (tx_step_i) tx_sh_q <= {tx_sh_q[SAMPLE_W-2:0], 1'b0};
      if (rise_i)         sdo_o   <= tx_step_i & tx_sh_q[SAMPLE_W-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q    <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= rx_done_i;
      if (rx_step_i) rx_sh_q   <= {rx_sh_q[SAMPLE_W-2:0], sdi_i};
      if (rx_done_i) rx_data_o <= {rx_sh_q[SAMPLE_W-2:0], sdi_i};
    end
  end

  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_load_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> !tx_load_o);
endmodule

// File: rtl/sap_port.sv
module sap_port #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic                sdi_i,
  output logic                sdo_o,
  input  logic                mode_i,
  input  logic [SAMPLE_W-1:0] tx_data_i,
  output logic                tx_load_o,
  output logic [SAMPLE_W-1:0] rx_data_o,
  output logic                rx_valid_o
);
  logic rise, fall, fsync_s, sdi_s;
  logic start, tx_step, rx_step, rx_done;

  sap_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bclk_i  (bclk_i),
    .fsync_i (fsync_i),
    .sdi_i   (sdi_i),
    .rise_o  (rise),
    .fall_o  (fall),
    .fsync_o (fsync_s),
    .sdi_o   (sdi_s)
  );

  sap_frame_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .fall_i    (fall),
    .fsync_i   (fsync_s),
    .mode_i    (mode_i),
    .start_o   (start),
    .tx_step_o (tx_step),
    .rx_step_o (rx_step),
    .rx_done_o (rx_done)
  );

  sap_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .start_i    (start),
    .tx_step_i  (tx_step),
    .rx_step_i  (rx_step),
    .rx_done_i  (rx_done),
    .sdi_i      (sdi_s),
    .tx_data_i  (tx_data_i),
    .sdo_o      (sdo_o),
    .tx_load_o  (tx_load_o),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o)
  );

  assert_sdo_on_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(rise));
  assert_rx_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(fall));
  assert_load_at_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> $past(rise) && $past(fsync_s));
endmodule

// File: tb/sap_port_test.sv
module sap_port_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bclk = 1'b0, fsync = 1'b0, sdi = 1'b0, mode = 1'b0;
  logic [15:0] tx_data = '0;
  logic        sdo, tx_load, rx_valid;
  logic [15:0] rx_data;

  int checks = 0, errors = 0, loads = 0;
  logic [15:0] rx_q[$];

  always #5 clk = ~clk;

  sap_port uut (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdi_i(sdi),
    .sdo_o(sdo), .mode_i(mode), .tx_data_i(tx_data), .tx_load_o(tx_load),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, evaluated on every clock
  bit hb1, hb2, hf1, hd1, m_fs_last, m_in, m_short;
  int m_cnt;
  logic [15:0] m_txw, m_rxw, m_data;
  bit m_sdo, m_valid, m_load;

  always @(posedge clk) begin
    if (!rst_n) begin
      hb1 = 0; hb2 = 0; hf1 = 0; hd1 = 0; m_fs_last = 0; m_in = 0; m_short = 0;
      m_cnt = 0; m_txw = '0; m_rxw = '0; m_data = '0; m_sdo = 0; m_valid = 0; m_load = 0;
    end else begin
      int base;
      m_valid = 0; m_load = 0;
      if (hb1 && !hb2) begin
        bit st;
        st = hf1 && !m_fs_last;
        m_fs_last = hf1;
        if (st) begin
          if (!m_in) m_short = mode;
          m_in = 1; m_cnt = 0; m_txw = tx_data; m_load = 1; m_sdo = 0;
        end else if (m_in) begin
          m_cnt++;
          base = m_short ? 1 : 16;
          m_sdo = (m_cnt >= base && m_cnt < base + 16) ? m_txw[15 - (m_cnt - base)] : 1'b0;
        end else m_sdo = 0;
      end else if (!hb1 && hb2 && m_in) begin
        base = m_short ? 1 : 16;
        if (m_cnt >= base && m_cnt < base + 16) begin
          m_rxw[15 - (m_cnt - base)] = hd1;
          if (m_cnt == base + 15) begin
            m_valid = 1; m_data = m_rxw; m_in = 0;
          end
        end
      end
      hb2 = hb1; hb1 = bclk; hf1 = fsync; hd1 = sdi;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(sdo === m_sdo, "R1 sdo timing", 32'(sdo), 32'(m_sdo));
    chk(rx_valid === m_valid, "R5 rx_valid timing", 32'(rx_valid), 32'(m_valid));
    chk(tx_load === m_load, "R2 tx_load timing", 32'(tx_load), 32'(m_load));
    if (m_valid) chk(rx_data === m_data, "R5 rx_data", 32'(rx_data), 32'(m_data));
    if (rx_valid) rx_q.push_back(rx_data);
    if (tx_load) loads++;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      fsync = 0; sdi = 0; bclk = 1;
      @(negedge clk); @(negedge clk);
      chk(sdo === 1'b0, "R6 sdo idle", 32'(sdo), 0);
      bclk = 0;
      @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic frame(input int ncyc, input int base, input logic [15:0] din,
                       input int flip_at, input bit flip_val, output logic [15:0] dout);
    dout = '0;
    for (int i = 0; i < ncyc; i++) begin
      bit dat;
      dat = (i >= base) && (i < base + 16);
      if (i == flip_at) mode = flip_val;
      fsync = (i == 0);
      sdi = dat ? din[15 - (i - base)] : 1'b0;
      bclk = 1;
      @(negedge clk); @(negedge clk);
      if (dat) dout[15 - (i - base)] = sdo;
      else chk(sdo === 1'b0, "R6 sdo outside channel 2", 32'(sdo), 0);
      bclk = 0;
      @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic expect_rx(input logic [15:0] exp, input string tag);
    chk(rx_q.size() != 0, tag, 32'(rx_q.size()), 1);
    if (rx_q.size() != 0) begin
      logic [15:0] w;
      w = rx_q.pop_front();
      chk(w === exp, tag, 32'(w), 32'(exp));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, d2;
    int l0;
    repeat (3) @(negedge clk);
    chk(sdo === 0 && tx_load === 0 && rx_valid === 0, "R9 reset outputs",
        {29'd0, sdo, tx_load, rx_valid}, 0);
    chk(rx_data === 16'h0, "R9 reset rx_data", 32'(rx_data), 0);
    rst_n = 1;
    idle(3);

    // R3 single full frame
    mode = 0; tx_data = 16'hA5C3; l0 = loads;
    frame(32, 16, 16'h3C96, -1, 0, d); idle(2);
    chk(d === 16'hA5C3, "R3 sdo word full frame", 32'(d), 32'hA5C3);
    expect_rx(16'h3C96, "R3 rx word full frame");
    chk(loads - l0 == 1, "R2 one load per frame", 32'(loads - l0), 1);

    // R3 back-to-back full frames, edge bit patterns
    tx_data = 16'hFFFF; frame(32, 16, 16'h0001, -1, 0, d);
    chk(d === 16'hFFFF, "R3 sdo all ones", 32'(d), 32'hFFFF);
    tx_data = 16'h8000; frame(32, 16, 16'hFFFE, -1, 0, d2); idle(2);
    chk(d2 === 16'h8000, "R3 sdo msb only", 32'(d2), 32'h8000);
    expect_rx(16'h0001, "R5 rx lsb only");
    expect_rx(16'hFFFE, "R5 rx back-to-back");

    // R4 short frames, back to back
    mode = 1; tx_data = 16'h1234;
    frame(17, 1, 16'hABCD, -1, 0, d);
    chk(d === 16'h1234, "R4 sdo short frame", 32'(d), 32'h1234);
    tx_data = 16'h0001; frame(17, 1, 16'h8000, -1, 0, d2); idle(2);
    chk(d2 === 16'h0001, "R4 sdo short lsb", 32'(d2), 32'h0001);
    expect_rx(16'hABCD, "R4 rx short frame");
    expect_rx(16'h8000, "R4 rx short back-to-back");

    // R7 mode change mid-frame ignored
    mode = 0; tx_data = 16'h5AA5;
    frame(32, 16, 16'hC33C, 5, 1, d); idle(2);
    chk(d === 16'h5AA5, "R7 sdo with mid-frame mode change", 32'(d), 32'h5AA5);
    expect_rx(16'hC33C, "R7 rx with mid-frame mode change");

    // R8 abort in full mode
    mode = 0; tx_data = 16'h0F0F; l0 = loads;
    frame(10, 16, 16'hDEAD, -1, 0, d);
    tx_data = 16'h7E81;
    frame(32, 16, 16'hBEEF, -1, 0, d); idle(2);
    chk(rx_q.size() == 1, "R8 one word after abort", 32'(rx_q.size()), 1);
    expect_rx(16'hBEEF, "R8 rx after abort");
    chk(d === 16'h7E81, "R8 tx reload on restart", 32'(d), 32'h7E81);
    chk(loads - l0 == 2, "R8 load on restart", 32'(loads - l0), 2);

    // R7 and R8: abort in short mode keeps short framing
    mode = 1; tx_data = 16'h3333;
    frame(6, 1, 16'h1111, 2, 0, d);
    tx_data = 16'hC0DE;
    frame(17, 1, 16'h6B2D, -1, 0, d); idle(2);
    chk(d === 16'hC0DE, "R7 restart keeps short mode sdo", 32'(d), 32'hC0DE);
    chk(rx_q.size() == 1, "R8 short abort discards", 32'(rx_q.size()), 1);
    expect_rx(16'h6B2D, "R7 restart keeps short mode rx");

    // R7 idle start picks up new mode
    tx_data = 16'h9669;
    frame(32, 16, 16'h2DB4, -1, 0, d); idle(2);
    chk(d === 16'h9669, "R7 mode relatched at idle start", 32'(d), 32'h9669);
    expect_rx(16'h2DB4, "R7 rx after relatch");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule